// File: doc/BRIEF.md
# Three-Phase Dead-Time and Interlock Controller

This block turns six active-low PWM commands, one high-side and one low-side command for each of three half-bridge legs, into six active-high gate-enable outputs. Every command passes a two-flop synchroniser and then a deglitch counter, so pulses shorter than a set number of clock cycles never reach a gate. Per leg, a guard stage keeps both switches from conducting together and holds a dead interval after any switch turns off before any switch of that leg may turn on.

A global enable, filtered separately with a longer window, and a low-side supply undervoltage flag force every gate off. Each leg also has a high-side undervoltage flag. When it clears, the high-side gate stays off until its command shows a new off-to-on transition. When the low-side flag clears, the low-side gates simply take the level of their commands again. All times are parameters in clock cycles. The undervoltage flags arrive as digital levels.

Top module: `tri_leg_gate_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all six gate outputs are 0. Every high-side arm flag is cleared.
- R2: Commands are active low: a 0 on `hs_cmd_n[i]` or `ls_cmd_n[i]` requests that switch on. A single steady request turns the matching gate on FILT_CYC+3 clock edges after the input changes.
- R3: A command level that lasts fewer than FILT_CYC cycles has no effect on the gates. A level that lasts FILT_CYC cycles or longer is passed on, delayed by the filter.
- R4: When both commands of a leg are active, both gates of that leg are 0. The two gates of a leg are never 1 together.
- R5: After either gate of a leg falls, neither gate of that leg rises in the following DEAD_CYC clock edges. With a turn-on already pending, the rise comes exactly DEAD_CYC+1 edges after the fall.
- R6: Once the filtered enable is low, all gates are 0. A low pulse on `drv_en` shorter than EN_FILT_CYC cycles leaves the gates unchanged.
- R7: While `hs_uv[i]` is set, `gate_hi[i]` is 0. After the flag clears, `gate_hi[i]` stays 0 until the filtered high-side command goes from off to on again.
- R8: While `ls_uv` is set, all six gates are 0. After it clears, the low-side gates follow their command levels with no new transition needed. A high-side gate whose arm flag is still set also resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_cmd_n | input | LEGS | High-side commands, active low |
| ls_cmd_n | input | LEGS | Low-side commands, active low |
| drv_en | input | 1 | Global enable, active high, filtered |
| ls_uv | input | 1 | Low-side supply undervoltage flag |
| hs_uv | input | LEGS | Per-leg high-side supply undervoltage flags |
| gate_hi | output | LEGS | High-side gate enables, registered |
| gate_lo | output | LEGS | Low-side gate enables, registered |

## Verification
The bench builds the block with FILT_CYC=4, EN_FILT_CYC=6 and DEAD_CYC=5. With these values, a pulse one cycle shorter than the filter and a pulse of exactly the filter length can be set side by side within a few dozen cycles. The full dead gap of six edges can be measured directly. Enable glitches just under the enable window can also be tried cheaply. The small values also let one short run chain the interlock, undervoltage re-arm and enable scenarios. A behavioural model built on input history compares both gate vectors on every cycle.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;
  // width of a counter that must hold values up to n-1 (at least one bit)
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  typedef struct packed {
    logic hi;
    logic lo;
  } leg_req_t;
endpackage

// File: rtl/cmd_deglitch.sv
module cmd_deglitch
  import gdrv_pkg::*;
#(
  parameter int LEN     = 30,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [1:0] sync_q;
  logic       s;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= {2{RST_VAL}};
    else     sync_q <= {sync_q[0], din};
  end
  assign s = sync_q[1];

  generate
    if (LEN == 0) begin : g_pass
      assign dout = s;
    end else begin : g_filt
      localparam int CW = cnt_w(LEN);
      logic [CW-1:0] run_q;
      logic          hold_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          run_q  <= '0;
          hold_q <= RST_VAL;
        end else if (s == hold_q) begin
          run_q <= '0;
        end else if (run_q == CW'(LEN - 1)) begin
          hold_q <= s;
          run_q  <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
      assign dout = hold_q;

      // R3
      filt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (s == hold_q) |=> $stable(hold_q));
    end
  endgenerate
endmodule

// File: rtl/leg_guard.sv
module leg_guard
  import gdrv_pkg::*;
#(
  parameter int DEAD = 31
) (
  input  logic clk,
  input  logic rst,
  input  logic hi_req,
  input  logic lo_req,
  input  logic kill,
  input  logic hs_uv,
  output logic gate_hi,
  output logic gate_lo
);
  localparam int DW = cnt_w(DEAD + 1);

  logic [DW-1:0] dead_q;
  logic          req_hi_d;
  logic          arm_q;
  logic          hi_rise, arm_nx, hi_ok, lo_ok, dead_idle;
  logic          hi_nx, lo_nx, any_off;

  always_comb begin
    hi_rise   = hi_req & ~req_hi_d;
    arm_nx    = hs_uv ? 1'b0 : (arm_q | hi_rise);
    hi_ok     = hi_req & ~lo_req & arm_nx & ~kill & ~hs_uv;
    lo_ok     = lo_req & ~hi_req & ~kill;
    dead_idle = (dead_q == '0);
    hi_nx     = hi_ok & (gate_hi | (dead_idle & ~gate_lo));
    lo_nx     = lo_ok & (gate_lo | (dead_idle & ~gate_hi));
    any_off   = (gate_hi & ~hi_nx) | (gate_lo & ~lo_nx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dead_q   <= '0;
      req_hi_d <= 1'b0;
      arm_q    <= 1'b0;
      gate_hi  <= 1'b0;
      gate_lo  <= 1'b0;
    end else begin
      req_hi_d <= hi_req;
      arm_q    <= arm_nx;
      gate_hi  <= hi_nx;
      gate_lo  <= lo_nx;
      if (any_off)         dead_q <= DW'(DEAD);
      else if (!dead_idle) dead_q <= dead_q - 1'b1;
    end
  end

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(gate_hi && gate_lo));

  // R5
  rise_lo_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_lo) |-> $past(!gate_hi));

  // R5
  rise_hi_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_hi) |-> $past(!gate_lo));

  generate
    if (DEAD > 0) begin : g_gap
      // R5
      fall_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(gate_hi) || $fell(gate_lo)) |=> (!gate_hi && !gate_lo));
    end
  endgenerate

  // R7
  hs_uv_off_chk: assert property (@(posedge clk) disable iff (rst)
    hs_uv |=> !gate_hi);
endmodule

// File: rtl/tri_leg_gate_ctrl.sv
module tri_leg_gate_ctrl
  import gdrv_pkg::*;
#(
  parameter int LEGS        = 3,
  parameter int FILT_CYC    = 30,
  parameter int EN_FILT_CYC = 60,
  parameter int DEAD_CYC    = 31
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LEGS-1:0] hs_cmd_n,
  input  logic [LEGS-1:0] ls_cmd_n,
  input  logic            drv_en,
  input  logic            ls_uv,
  input  logic [LEGS-1:0] hs_uv,
  output logic [LEGS-1:0] gate_hi,
  output logic [LEGS-1:0] gate_lo
);
  logic en_f;
  logic ls_uv_s;
  logic kill;

  cmd_deglitch #(.LEN(EN_FILT_CYC), .RST_VAL(1'b0)) u_en_filt (
    .clk(clk), .rst(rst), .din(drv_en), .dout(en_f));

  cmd_deglitch #(.LEN(0), .RST_VAL(1'b0)) u_lsuv_sync (
    .clk(clk), .rst(rst), .din(ls_uv), .dout(ls_uv_s));

  assign kill = ~en_f | ls_uv_s;

  generate
    for (genvar g = 0; g < LEGS; g++) begin : g_leg
      logic     hi_n_f, lo_n_f, hs_uv_s;
      leg_req_t req;

      cmd_deglitch #(.LEN(FILT_CYC), .RST_VAL(1'b1)) u_hi_filt (
        .clk(clk), .rst(rst), .din(hs_cmd_n[g]), .dout(hi_n_f));
      cmd_deglitch #(.LEN(FILT_CYC), .RST_VAL(1'b1)) u_lo_filt (
        .clk(clk), .rst(rst), .din(ls_cmd_n[g]), .dout(lo_n_f));
      cmd_deglitch #(.LEN(0), .RST_VAL(1'b0)) u_hsuv_sync (
        .clk(clk), .rst(rst), .din(hs_uv[g]), .dout(hs_uv_s));

      assign req.hi = ~hi_n_f;
      assign req.lo = ~lo_n_f;

      leg_guard #(.DEAD(DEAD_CYC)) u_guard (
        .clk(clk), .rst(rst), .hi_req(req.hi), .lo_req(req.lo),
        .kill(kill), .hs_uv(hs_uv_s),
        .gate_hi(gate_hi[g]), .gate_lo(gate_lo[g]));
    end
  endgenerate

  // R6
  en_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en_f |=> (gate_hi == '0 && gate_lo == '0));

  // R8
  ls_uv_off_chk: assert property (@(posedge clk) disable iff (rst)
    ls_uv_s |=> (gate_hi == '0 && gate_lo == '0));
endmodule

// File: tb/test_tri_leg_gate_ctrl.sv
module test_tri_leg_gate_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LEGS    = 3;
  localparam int FILT    = 4;
  localparam int EN_FILT = 6;
  localparam int DEAD    = 5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [LEGS-1:0] hs_cmd_n = '1;
  logic [LEGS-1:0] ls_cmd_n = '1;
  logic            drv_en = 1'b0;
  logic            ls_uv = 1'b0;
  logic [LEGS-1:0] hs_uv = '0;
  logic [LEGS-1:0] gate_hi, gate_lo;

  int    compared = 0;
  int    mismatched = 0;
  bit    done = 0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_leg_gate_ctrl #(.LEGS(LEGS), .FILT_CYC(FILT), .EN_FILT_CYC(EN_FILT),
                      .DEAD_CYC(DEAD)) i_tri_leg_gate_ctrl (
    .clk(clk), .rst(rst), .hs_cmd_n(hs_cmd_n), .ls_cmd_n(ls_cmd_n),
    .drv_en(drv_en), .ls_uv(ls_uv), .hs_uv(hs_uv),
    .gate_hi(gate_hi), .gate_lo(gate_lo));

  // ---------------- behavioural reference built on input history ----------
  logic [15:0]     hh [LEGS];
  logic [15:0]     hl [LEGS];
  logic [15:0]     huh [LEGS];
  logic [15:0]     he = '0, hul = '0;
  logic [LEGS-1:0] mqh = '1, mql = '1, mhd = '0, marm = '0, mgh = '0, mgl = '0;
  logic            mqe = 1'b0;
  int              lastf [LEGS];
  int              edge_n = 0;

  // output of a deglitcher: newest sample is bit 0, the filter sees bit 2
  function automatic logic filt(input logic [15:0] h, input int len, input logic q);
    logic v;
    v = h[2];
    if (v == q) return q;
    for (int k = 2; k <= len + 1; k++) if (h[k] != v) return q;
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LEGS; i++) begin
        hh[i] = '1; hl[i] = '1; huh[i] = '0; lastf[i] = -1000;
      end
      he = '0; hul = '0;
      mqh = '1; mql = '1; mhd = '0; marm = '0; mgh = '0; mgl = '0;
      mqe = 1'b0;
      edge_n = 0;
    end else begin
      logic en_old, uvl, kill_m;
      he  = {he[14:0], drv_en};
      hul = {hul[14:0], ls_uv};
      en_old = mqe;
      uvl    = hul[2];
      kill_m = ~en_old | uvl;
      for (int i = 0; i < LEGS; i++) begin
        logic hreq, lreq, uvh, arm_n, hok, lok, gap_ok, nh, nl;
        hh[i]  = {hh[i][14:0], hs_cmd_n[i]};
        hl[i]  = {hl[i][14:0], ls_cmd_n[i]};
        huh[i] = {huh[i][14:0], hs_uv[i]};
        hreq   = ~mqh[i];
        lreq   = ~mql[i];
        uvh    = huh[i][2];
        arm_n  = uvh ? 1'b0 : (marm[i] | (hreq & ~mhd[i]));
        hok    = hreq & ~lreq & arm_n & ~kill_m & ~uvh;
        lok    = lreq & ~hreq & ~kill_m;
        gap_ok = (edge_n - lastf[i]) >= DEAD + 1;
        nh     = hok & (mgh[i] | (gap_ok & ~mgl[i]));
        nl     = lok & (mgl[i] | (gap_ok & ~mgh[i]));
        if ((mgh[i] & ~nh) | (mgl[i] & ~nl)) lastf[i] = edge_n;
        mgh[i]  = nh;
        mgl[i]  = nl;
        marm[i] = arm_n;
        mhd[i]  = hreq;
        mqh[i]  = filt(hh[i], FILT, mqh[i]);
        mql[i]  = filt(hl[i], FILT, mql[i]);
      end
      mqe = filt(he, EN_FILT, mqe);
      edge_n++;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      compared++;
      if (gate_hi !== mgh || gate_lo !== mgl) begin
        mismatched++;
        $display("FAIL %s model compare at %0t: actual hi=%b lo=%b expected hi=%b lo=%b",
                 phase, $time, gate_hi, gate_lo, mgh, mgl);
      end
    end
  end

  // ---------------- directed checks --------------------------------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    logic seen;
    logic [5:0] snap;
    logic steady;
    int gap;
    cyc(4);
    chk("R1 reset gates", {2'b0, gate_hi, gate_lo}, 8'h00);
    rst = 1'b0;
    cyc(1);
    chk("R1 first cycle after reset", {2'b0, gate_hi, gate_lo}, 8'h00);
    drv_en = 1'b1;
    cyc(15);

    // R2: active-low low-side request on leg 0
    phase = "R2";
    ls_cmd_n[0] = 1'b0;
    cyc(FILT + 2);
    chk("R2 not yet on", {7'b0, gate_lo[0]}, 8'h00);
    cyc(1);
    chk("R2 on after FILT+3 edges", {7'b0, gate_lo[0]}, 8'h01);
    cyc(15);
    chk("R2 leg0 low on", {2'b0, gate_hi, gate_lo}, 8'h01);

    // R5: hand over leg 0 from low to high, measure the gap
    phase = "R5";
    hs_cmd_n[0] = 1'b0;
    ls_cmd_n[0] = 1'b1;
    gap = 0;
    for (int k = 0; k < 60 && gate_lo[0]; k++) cyc(1);
    for (int k = 0; k < 60 && !gate_hi[0]; k++) begin
      gap++;
      cyc(1);
    end
    chk("R5 dead gap edges", 8'(gap), 8'(DEAD + 1));
    chk("R5 leg0 high on", {2'b0, gate_hi, gate_lo}, 8'h08);

    // R3: short and boundary pulses
    phase = "R3";
    ls_cmd_n[1] = 1'b0;
    cyc(FILT - 1);
    ls_cmd_n[1] = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < 20; k++) begin cyc(1); seen |= gate_lo[1]; end
    chk("R3 short on-pulse blocked", {7'b0, seen}, 8'h00);
    ls_cmd_n[1] = 1'b0;
    cyc(FILT);
    ls_cmd_n[1] = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < 20; k++) begin cyc(1); seen |= gate_lo[1]; end
    chk("R3 full-length pulse passed", {7'b0, seen}, 8'h01);
    hs_cmd_n[0] = 1'b1;
    cyc(FILT - 1);
    hs_cmd_n[0] = 1'b0;
    steady = 1'b1;
    for (int k = 0; k < 20; k++) begin cyc(1); steady &= gate_hi[0]; end
    chk("R3 short off-pulse blocked", {7'b0, steady}, 8'h01);

    // R4: both commands of leg 2 active
    phase = "R4";
    hs_cmd_n[2] = 1'b0;
    ls_cmd_n[2] = 1'b0;
    cyc(20);
    chk("R4 both active both off", {6'b0, gate_hi[2], gate_lo[2]}, 8'h00);
    ls_cmd_n[2] = 1'b1;
    cyc(20);
    chk("R4 high remains", {6'b0, gate_hi[2], gate_lo[2]}, 8'h02);
    ls_cmd_n[2] = 1'b0;
    cyc(20);
    chk("R4 both again off", {6'b0, gate_hi[2], gate_lo[2]}, 8'h00);
    hs_cmd_n[2] = 1'b1;
    cyc(20);
    chk("R4 low remains", {6'b0, gate_hi[2], gate_lo[2]}, 8'h01);

    // R6: enable glitch and enable off
    phase = "R6";
    snap = {gate_hi, gate_lo};
    drv_en = 1'b0;
    cyc(EN_FILT - 1);
    drv_en = 1'b1;
    steady = 1'b1;
    for (int k = 0; k < 20; k++) begin cyc(1); steady &= ({gate_hi, gate_lo} == snap); end
    chk("R6 short enable glitch ignored", {7'b0, steady}, 8'h01);
    drv_en = 1'b0;
    cyc(20);
    chk("R6 enable low all off", {2'b0, gate_hi, gate_lo}, 8'h00);
    drv_en = 1'b1;
    cyc(30);
    chk("R6 enable back restores", {2'b0, gate_hi, gate_lo}, {2'b0, snap});

    // R7: high-side undervoltage on leg 0 needs a new edge
    phase = "R7";
    hs_uv[0] = 1'b1;
    cyc(10);
    chk("R7 hs uv forces off", {7'b0, gate_hi[0]}, 8'h00);
    hs_uv[0] = 1'b0;
    cyc(20);
    chk("R7 stays off without edge", {7'b0, gate_hi[0]}, 8'h00);
    hs_cmd_n[0] = 1'b1;
    cyc(15);
    hs_cmd_n[0] = 1'b0;
    cyc(20);
    chk("R7 new edge re-arms", {7'b0, gate_hi[0]}, 8'h01);

    // R8: low-side undervoltage
    phase = "R8";
    ls_cmd_n[1] = 1'b0;
    cyc(20);
    chk("R8 before uv", {2'b0, gate_hi, gate_lo}, 8'h0E);
    ls_uv = 1'b1;
    cyc(10);
    chk("R8 ls uv all off", {2'b0, gate_hi, gate_lo}, 8'h00);
    ls_uv = 1'b0;
    cyc(20);
    chk("R8 level recovery", {2'b0, gate_hi, gate_lo}, 8'h0E);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog in %s actual=running expected=finished", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule